// File: doc/BRIEF.md
# Shared High-Byte Staging Bridge for 16-bit Timer Registers

This block lets an 8-bit processor bus reach a set of 16-bit timer registers: a counter, two compare registers and a capture register. Each register appears as two byte addresses. One 8-bit staging byte is shared by all of them, so a 16-bit value moves as a pair of byte accesses without tearing. Software writes the upper byte first and reads the lower byte first. Keeping the pair atomic against other code is left to software.

The timer core supplies the live 16-bit values. The bridge returns read bytes and issues one-cycle commit strobes carrying full 16-bit values. For the counter, the bridge also merges the bus write with the core's clear and count requests into a single prioritised load.

Address encoding: bit 0 selects the byte (1 = upper, 0 = lower). The bits above it select the register: 0 counter, 1 compare A, 2 compare B, 3 capture. All outputs are registered, so every response appears one clock after the strobe that caused it.

Top module: `wide_reg_bridge`

## Requirements
- R1: A write to an upper-byte address loads only the staging byte. No commit strobe and no counter load follow it.
- R2: A write to a lower-byte address of register i pulses commit_stb bit i (one-hot) in the next cycle. commit_val then equals {staging byte, written byte}.
- R3: A read of a lower-byte address returns that register's live low byte on bus_rdata in the next cycle. In the same cycle it copies the register's live high byte into the staging byte.
- R4: A read of the counter or capture upper-byte address returns the staging byte, not the live high byte.
- R5: A read of a compare register's upper-byte address returns that register's live high byte directly. The staging byte is left unchanged.
- R6: One upper-byte write can supply the upper half for several following lower-byte writes to different registers. The staging byte is not cleared by a commit.
- R7: The counter load has a fixed priority: bus write first, then clear (load 0), then count (load live+1, wrapping 0xFFFF to 0x0000). The load is reported on cnt_load/cnt_load_val in the next cycle.
- R8: After reset, the staging byte, bus_rdata, commit_stb and cnt_load are all zero.
- R9: A lower-byte read of another register between an upper-byte write and its lower-byte write replaces the pending upper byte. The commit then carries the other register's high byte.
- R10: When read and write strobes are asserted together, only the write takes effect, and bus_rdata keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | {register index, upper-byte select} |
| bus_wdata | input | 8 | Write byte |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| live_vals | input | 64 | Live register values, register i at bits [16i+15:16i] |
| tmr_clr | input | 1 | Core request to clear the counter |
| tmr_step | input | 1 | Core request to advance the counter |
| bus_rdata | output | 8 | Registered read byte |
| commit_stb | output | 4 | One-hot 16-bit write commit strobe |
| commit_val | output | 16 | Value committed with commit_stb |
| cnt_load | output | 1 | Counter load strobe |
| cnt_load_val | output | 16 | Value loaded into the counter |

## Verification
The bench uses the default parameters: four registers of two bytes each, the counter at index 0, and direct upper-byte reads for indexes 1 and 2. With these values, both the staged and the direct upper-byte read paths can be exercised, as can the counter arbitration. The counter value 0xFFFF lets the wrap of the count path be checked at the 16-bit boundary. Changing the live values between the lower-byte and upper-byte reads shows whether a read returned a snapshot or the live value.

// File: rtl/wrb_pkg.sv
package wrb_pkg;
  typedef struct packed {
    logic rd_lo;
    logic rd_hi;
    logic wr_lo;
    logic wr_hi;
  } wrb_acc_t;
endpackage

// File: rtl/wrb_decode.sv
module wrb_decode
  import wrb_pkg::*;
#(
  parameter int NREG = 4,
  localparam int IW = $clog2(NREG),
  localparam int AW = IW + 1
) (
  input  logic [AW-1:0] addr,
  input  logic          rd,
  input  logic          wr,
  output wrb_acc_t      acc,
  output logic [IW-1:0] idx
);
  logic rd_eff;

  // write wins a collision; the read is dropped (R10)
  assign rd_eff    = rd & ~wr;
  assign idx       = addr[AW-1:1];
  assign acc.rd_lo = rd_eff & ~addr[0];
  assign acc.rd_hi = rd_eff &  addr[0];
  assign acc.wr_lo = wr & ~addr[0];
  assign acc.wr_hi = wr &  addr[0];
endmodule

// File: rtl/wrb_hold.sv
module wrb_hold
  import wrb_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  wrb_acc_t      acc,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] live_hi,
  output logic [DW-1:0] temp_q
);
  always_ff @(posedge clk) begin
    if (rst)             temp_q <= '0;
    else if (acc.wr_hi)  temp_q <= wdata;
    else if (acc.rd_lo)  temp_q <= live_hi;
  end

  a_r8_temp_reset: assert property (@(posedge clk) rst |=> temp_q == '0);
  a_r1_temp_from_write: assert property (@(posedge clk) disable iff (rst)
    acc.wr_hi |=> temp_q == $past(wdata));
  a_r3_temp_snapshot: assert property (@(posedge clk) disable iff (rst)
    acc.rd_lo |=> temp_q == $past(live_hi));
  a_r6_temp_kept: assert property (@(posedge clk) disable iff (rst)
    (!acc.wr_hi && !acc.rd_lo) |=> $stable(temp_q));
endmodule

// File: rtl/wrb_cnt_arb.sv
module wrb_cnt_arb #(
  parameter int RW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cpu_wr,
  input  logic [RW-1:0] cpu_val,
  input  logic          clr,
  input  logic          step,
  input  logic [RW-1:0] live,
  output logic          load,
  output logic [RW-1:0] load_val
);
  always_ff @(posedge clk) begin
    if (rst) begin
      load     <= 1'b0;
      load_val <= '0;
    end else begin
      load <= cpu_wr | clr | step;
      if (cpu_wr)     load_val <= cpu_val;
      else if (clr)   load_val <= '0;
      else if (step)  load_val <= live + RW'(1);
    end
  end

  a_r7_cpu_wins: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && (clr || step)) |=> (load && load_val == $past(cpu_val)));
  a_r7_clear_over_step: assert property (@(posedge clk) disable iff (rst)
    (!cpu_wr && clr) |=> (load && load_val == '0));
  a_r7_idle_no_load: assert property (@(posedge clk) disable iff (rst)
    (!cpu_wr && !clr && !step) |=> !load);
endmodule

// File: rtl/wide_reg_bridge.sv
module wide_reg_bridge
  import wrb_pkg::*;
#(
  parameter int              DW        = 8,
  parameter int              NREG      = 4,
  parameter int              CNT_IDX   = 0,
  parameter logic [NREG-1:0] HI_DIRECT = NREG'(6),
  localparam int             RW        = 2 * DW,
  localparam int             IW        = $clog2(NREG),
  localparam int             AW        = IW + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [AW-1:0]      bus_addr,
  input  logic [DW-1:0]      bus_wdata,
  input  logic               bus_rd,
  input  logic               bus_wr,
  input  logic [NREG*RW-1:0] live_vals,
  input  logic               tmr_clr,
  input  logic               tmr_step,
  output logic [DW-1:0]      bus_rdata,
  output logic [NREG-1:0]    commit_stb,
  output logic [RW-1:0]      commit_val,
  output logic               cnt_load,
  output logic [RW-1:0]      cnt_load_val
);
  wrb_acc_t      acc;
  logic [IW-1:0] idx;
  logic [DW-1:0] temp_q;
  logic [DW-1:0] lo_b [NREG];
  logic [DW-1:0] hi_b [NREG];
  logic [DW-1:0] hi_rd [NREG];
  logic [DW-1:0] sel_lo, sel_hi_live, sel_hi_rd;
  logic          cnt_wr;

  wrb_decode #(.NREG(NREG)) u_dec (
    .addr(bus_addr), .rd(bus_rd), .wr(bus_wr), .acc(acc), .idx(idx)
  );

  generate
    for (genvar i = 0; i < NREG; i++) begin : g_reg
      assign lo_b[i] = live_vals[i*RW +: DW];
      assign hi_b[i] = live_vals[i*RW+DW +: DW];
      if (HI_DIRECT[i]) begin : g_direct
        assign hi_rd[i] = hi_b[i];
      end else begin : g_staged
        assign hi_rd[i] = temp_q;
      end
      always_ff @(posedge clk) begin
        if (rst) commit_stb[i] <= 1'b0;
        else     commit_stb[i] <= acc.wr_lo && (idx == IW'(i));
      end
    end
  endgenerate

  assign sel_lo      = lo_b[idx];
  assign sel_hi_live = hi_b[idx];
  assign sel_hi_rd   = hi_rd[idx];

  wrb_hold #(.DW(DW)) u_hold (
    .clk(clk), .rst(rst), .acc(acc), .wdata(bus_wdata),
    .live_hi(sel_hi_live), .temp_q(temp_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      commit_val <= '0;
    end else begin
      if (acc.rd_lo)      bus_rdata <= sel_lo;
      else if (acc.rd_hi) bus_rdata <= sel_hi_rd;
      if (acc.wr_lo)      commit_val <= {temp_q, bus_wdata};
    end
  end

  assign cnt_wr = acc.wr_lo && (idx == IW'(CNT_IDX));

  wrb_cnt_arb #(.RW(RW)) u_arb (
    .clk(clk), .rst(rst), .cpu_wr(cnt_wr), .cpu_val({temp_q, bus_wdata}),
    .clr(tmr_clr), .step(tmr_step),
    .live(live_vals[CNT_IDX*RW +: RW]),
    .load(cnt_load), .load_val(cnt_load_val)
  );

  a_r2_commit_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(commit_stb));
  a_r2_low_write_commits: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !bus_addr[0]) |=> ($countones(commit_stb) == 1));
  a_r1_high_write_silent: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr[0]) |=> (commit_stb == '0));
  a_r10_collide_holds_rdata: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_wr) |=> $stable(bus_rdata));
endmodule

// File: tb/wide_reg_bridge_bench.sv
module wide_reg_bridge_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [15:0] live [4];
  logic [63:0] live_vals;
  logic        tmr_clr = 1'b0, tmr_step = 1'b0;
  logic [7:0]  bus_rdata;
  logic [3:0]  commit_stb;
  logic [15:0] commit_val;
  logic        cnt_load;
  logic [15:0] cnt_load_val;

  logic [7:0]  o_rd;
  logic [3:0]  o_stb;
  logic [15:0] o_val;
  logic        o_ld;
  logic [15:0] o_ldv;

  int n_run = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  assign live_vals = {live[3], live[2], live[1], live[0]};

  wide_reg_bridge u_wide_reg_bridge (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .live_vals(live_vals),
    .tmr_clr(tmr_clr), .tmr_step(tmr_step), .bus_rdata(bus_rdata),
    .commit_stb(commit_stb), .commit_val(commit_val),
    .cnt_load(cnt_load), .cnt_load_val(cnt_load_val)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic [2:0] a, input logic [7:0] d, input logic r, input logic w,
                     input logic c, input logic s);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_rd = r; bus_wr = w; tmr_clr = c; tmr_step = s;
    @(posedge clk); #1;
    o_rd = bus_rdata; o_stb = commit_stb; o_val = commit_val;
    o_ld = cnt_load; o_ldv = cnt_load_val;
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b0; tmr_clr = 1'b0; tmr_step = 1'b0;
  endtask

  task automatic t_reset();
    chk("R8 rdata", 32'(bus_rdata), 32'h0);
    chk("R8 commit_stb", 32'(commit_stb), 32'h0);
    chk("R8 cnt_load", 32'(cnt_load), 32'h0);
    cyc(3'd1, 8'h00, 1, 0, 0, 0);
    chk("R8 staging byte zero", 32'(o_rd), 32'h0);
  endtask

  task automatic t_high_write();
    cyc(3'd5, 8'h3E, 0, 1, 0, 0);
    chk("R1 no commit", 32'(o_stb), 32'h0);
    chk("R1 no counter load", 32'(o_ld), 32'h0);
    cyc(3'd1, 8'h00, 1, 0, 0, 0);
    chk("R1 R4 staging readback", 32'(o_rd), 32'h3E);
  endtask

  task automatic t_low_write();
    cyc(3'd0, 8'h77, 0, 1, 0, 0);
    chk("R2 strobe counter", 32'(o_stb), 32'h1);
    chk("R2 commit value", 32'(o_val), 32'h3E77);
    chk("R7 counter load", 32'(o_ld), 32'h1);
    chk("R7 counter load value", 32'(o_ldv), 32'h3E77);
  endtask

  task automatic t_low_read();
    live[0] = 16'hABCD;
    cyc(3'd0, 8'h00, 1, 0, 0, 0);
    chk("R3 low byte", 32'(o_rd), 32'hCD);
    live[0] = 16'h55CD;
    cyc(3'd1, 8'h00, 1, 0, 0, 0);
    chk("R3 R4 snapshot high", 32'(o_rd), 32'hAB);
  endtask

  task automatic t_capture_hi();
    live[3] = 16'h4455;
    cyc(3'd6, 8'h00, 1, 0, 0, 0);
    chk("R3 capture low", 32'(o_rd), 32'h55);
    live[3] = 16'hEE55;
    cyc(3'd7, 8'h00, 1, 0, 0, 0);
    chk("R4 capture high staged", 32'(o_rd), 32'h44);
  endtask

  task automatic t_cmp_direct();
    live[1] = 16'h9A12;
    cyc(3'd3, 8'h00, 1, 0, 0, 0);
    chk("R5 compare A high", 32'(o_rd), 32'h9A);
    live[1] = 16'h6612;
    cyc(3'd3, 8'h00, 1, 0, 0, 0);
    chk("R5 compare A high live", 32'(o_rd), 32'h66);
    live[2] = 16'hC3C3;
    cyc(3'd5, 8'h00, 1, 0, 0, 0);
    chk("R5 compare B high", 32'(o_rd), 32'hC3);
    cyc(3'd1, 8'h00, 1, 0, 0, 0);
    chk("R5 staging untouched", 32'(o_rd), 32'h44);
  endtask

  task automatic t_shared_reuse();
    cyc(3'd1, 8'h5A, 0, 1, 0, 0);
    cyc(3'd2, 8'h01, 0, 1, 0, 0);
    chk("R6 strobe cmpA", 32'(o_stb), 32'h2);
    chk("R6 value cmpA", 32'(o_val), 32'h5A01);
    cyc(3'd4, 8'h02, 0, 1, 0, 0);
    chk("R6 strobe cmpB", 32'(o_stb), 32'h4);
    chk("R6 value cmpB", 32'(o_val), 32'h5A02);
    cyc(3'd6, 8'h03, 0, 1, 0, 0);
    chk("R6 strobe capture", 32'(o_stb), 32'h8);
    chk("R6 value capture", 32'(o_val), 32'h5A03);
    cyc(3'd1, 8'h00, 1, 0, 0, 0);
    chk("R6 staging kept", 32'(o_rd), 32'h5A);
  endtask

  task automatic t_cnt_priority();
    live[0] = 16'h1234;
    cyc(3'd0, 8'h00, 0, 0, 0, 1);
    chk("R7 step load", 32'(o_ld), 32'h1);
    chk("R7 step value", 32'(o_ldv), 32'h1235);
    cyc(3'd0, 8'h00, 0, 0, 1, 1);
    chk("R7 clear over step", 32'(o_ldv), 32'h0);
    cyc(3'd1, 8'hBE, 0, 1, 0, 0);
    cyc(3'd0, 8'hEF, 0, 1, 1, 1);
    chk("R7 write wins", 32'(o_ldv), 32'hBEEF);
    chk("R7 write commit", 32'(o_stb), 32'h1);
    live[0] = 16'hFFFF;
    cyc(3'd0, 8'h00, 0, 0, 0, 1);
    chk("R7 step wrap", 32'(o_ldv), 32'h0);
    cyc(3'd0, 8'h00, 0, 0, 0, 0);
    chk("R7 idle no load", 32'(o_ld), 32'h0);
  endtask

  task automatic t_interleave();
    live[3] = 16'h7788;
    cyc(3'd1, 8'h11, 0, 1, 0, 0);
    cyc(3'd6, 8'h00, 1, 0, 0, 0);
    chk("R9 capture low read", 32'(o_rd), 32'h88);
    cyc(3'd0, 8'h22, 0, 1, 0, 0);
    chk("R9 corrupted commit", 32'(o_val), 32'h7722);
  endtask

  task automatic t_collide();
    live[2] = 16'h00A1;
    cyc(3'd4, 8'h00, 1, 0, 0, 0);
    chk("R10 setup read", 32'(o_rd), 32'hA1);
    cyc(3'd1, 8'h3C, 1, 1, 0, 0);
    chk("R10 rdata held", 32'(o_rd), 32'hA1);
    cyc(3'd1, 8'h00, 1, 0, 0, 0);
    chk("R10 write took effect", 32'(o_rd), 32'h3C);
  endtask

  initial begin
    #(8 * 200000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) live[i] = 16'h0000;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk); #1;
    t_reset();
    t_high_write();
    t_low_write();
    t_low_read();
    t_capture_hi();
    t_cmp_direct();
    t_shared_reuse();
    t_cnt_priority();
    t_interleave();
    t_collide();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule